// File: doc/BRIEF.md
# Programmable Reference Divider with Test Output Select

This block takes a reference clock and divides it by one of fifteen legal ratios, chosen with a 4-bit code, to give the comparison rate of a synthesiser loop. The result leaves the block as a one-cycle comparison pulse. A 4-bit code value selects one of two ratio families: powers of two from 2 to 256, and three times a power of two from 6 to 384. One code value has no ratio. When it becomes active, the divider stops and flags the error.

A monitor pin can show the raw reference, the comparison pulse, or a steady high level. The select bits power up so that the comparison pulse is on the pin. The code and the select bits are captured together on a write strobe. A new code waits for the end of the current division period, so the output never carries a shortened period.

A separate path on the RF clock holds an optional divide-by-two prescaler. The RF clock either passes through it to the following counter or bypasses it. That select is a static level.

Top module: `refdiv_select`

## Requirements
- R1: Codes 0000 to 0111 (code_in[3]=0) give a comparison pulse every 2^(code+1) reference cycles, that is 2, 4, 8, 16, 32, 64, 128 or 256.
- R2: Codes 1001 to 1111 give a comparison pulse every 3 x 2^(code-8) reference cycles, that is 6, 12, 24, 48, 96, 192 or 384.
- R3: While code 1000 is active, comp_pulse stays low and code_err is high. A legal code written while 1000 is active is taken on the next clock edge, and pulses resume at that code's period.
- R4: A code written with cfg_wr takes effect only at the next terminal count. The period in progress, and the full period that starts at that terminal count, still use the old ratio when the write lands in the pulse cycle.
- R5: comp_pulse is high for exactly one reference cycle per period.
- R6: With the output enable written 1 and the source select written 0, ref_comp_out follows ref_clk.
- R7: With the output enable and the source select both 1, ref_comp_out equals comp_pulse.
- R8: With the output enable written 0, ref_comp_out is held high.
- R9: After reset the output enable and the source select are 1, the active code is 0000 (ratio 2), and code_err is low.
- R10: With pe=1, rf_out toggles on every rising edge of rf_clk, which halves the frequency. With pe=0, rf_out equals rf_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the divider and the config registers |
| rf_clk | input | 1 | RF input clock for the prescaler path |
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| cfg_wr | input | 1 | Write strobe; captures code_in, re_in and rts_in |
| code_in | input | 4 | Ratio code |
| re_in | input | 1 | Monitor output enable |
| rts_in | input | 1 | Monitor source: 1 selects the comparison pulse, 0 selects the reference |
| pe | input | 1 | Static prescaler enable |
| comp_pulse | output | 1 | One-cycle comparison pulse |
| ref_comp_out | output | 1 | Monitor output |
| rf_out | output | 1 | RF clock to the programmable counter, halved or passed through |
| code_err | output | 1 | High while the illegal code is active |

## Verification
The bench measures the spacing of pulses for every legal code. A ratio decode that is off by one or that swaps the two families shows up as a wrong interval. Each code is written in the cycle of a pulse, so a design that applied the code immediately would shorten the next interval and break the rule against runt pulses. The bench holds the illegal code for hundreds of cycles and watches for any stray pulse. It then checks recovery, which a design would miss if it waited for a terminal count that never comes. The monitor pin is sampled in both clock phases for each select setting, and the prescaler output is checked for toggling against bypass.

// File: rtl/refdiv_select.sv
module refdiv_select #(
  parameter int CW = 9
) (
  input  logic       ref_clk,
  input  logic       rf_clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] code_in,
  input  logic       re_in,
  input  logic       rts_in,
  input  logic       pe,
  output logic       comp_pulse,
  output logic       ref_comp_out,
  output logic       rf_out,
  output logic       code_err
);
  localparam logic [3:0] BAD_CODE = 4'b1000;

  logic [3:0]    pend_code, act_code;
  logic [CW-1:0] cnt;
  logic          oe_q, src_q, half_q;

  function automatic logic [CW-1:0] span_of(input logic [3:0] c);
    span_of = c[3] ? (CW'(3) << c[2:0]) : (CW'(2) << c[2:0]);
  endfunction

  assign code_err   = (act_code == BAD_CODE);
  assign comp_pulse = (cnt == '0) && !code_err;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code <= '0;
      act_code  <= '0;
      cnt       <= CW'(1);
      oe_q      <= 1'b1;
      src_q     <= 1'b1;
    end else begin
      if (cfg_wr) begin
        pend_code <= code_in;
        oe_q      <= re_in;
        src_q     <= rts_in;
      end
      if (code_err || cnt == '0) begin
        act_code <= pend_code;
        cnt      <= span_of(pend_code) - CW'(1);
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign ref_comp_out = !oe_q ? 1'b1 : (src_q ? comp_pulse : ref_clk);

  always_ff @(posedge rf_clk or negedge rst_n)
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;

  assign rf_out = pe ? half_q : rf_clk;

  assert_err_silent_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    code_err |-> !comp_pulse);

  assert_single_pulse_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    comp_pulse |=> !comp_pulse);

  assert_code_at_tc_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (act_code != $past(act_code)) && !$past(code_err) |-> $past(comp_pulse));

  assert_out_held_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(cfg_wr && !re_in) |-> ref_comp_out);
endmodule

// File: tb/sim_refdiv_select.sv
module sim_refdiv_select;
  logic ref_clk = 1'b0, rf_clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, re_in = 1'b1, rts_in = 1'b1, pe = 1'b0;
  logic [3:0] code_in = '0;
  logic comp_pulse, ref_comp_out, rf_out, code_err;

  int checks = 0, fails = 0, since = 0;
  int exp_q[$];
  logic [3:0] cur = '0;

  always #4 ref_clk = ~ref_clk;
  always #3 rf_clk = ~rf_clk;

  refdiv_select u0 (.ref_clk, .rf_clk, .rst_n, .cfg_wr, .code_in, .re_in,
                    .rts_in, .pe, .comp_pulse, .ref_comp_out, .rf_out, .code_err);

  function automatic int exp_span(input logic [3:0] c);
    if (!c[3]) return 2 ** (int'(c) + 1);
    return 3 * (2 ** (int'(c) - 8));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge ref_clk) if (rst_n) begin
    since++;
    if (comp_pulse) begin
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check(since == e, cur[3] ? "R2 interval" : "R1/R4 interval", since, e);
      end
      since = 0;
    end
  end

  task automatic sync_set(input logic [3:0] c, input logic re, input logic rts, input int k);
    do @(negedge ref_clk); while (!comp_pulse);
    #1;
    cfg_wr = 1'b1; code_in = c; re_in = re; rts_in = rts;
    exp_q.push_back(exp_span(cur));
    cur = c;
    for (int i = 0; i < k; i++) exp_q.push_back(exp_span(c));
    @(posedge ref_clk); #1 cfg_wr = 1'b0;
    while (exp_q.size() > 0) @(negedge ref_clk);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check(code_err == 1'b0, "R9 err after reset", code_err, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge ref_clk);
      check(ref_comp_out == comp_pulse, "R9 default output select", ref_comp_out, comp_pulse);
    end
    sync_set(4'd0, 1'b1, 1'b1, 3);

    for (int c = 1; c < 8; c++) sync_set(4'(c), 1'b1, 1'b1, 2);
    for (int c = 9; c < 16; c++) sync_set(4'(c), 1'b1, 1'b1, 2);
    sync_set(4'd0, 1'b1, 1'b1, 2);

    begin
      int hi = 0, lo = 0, run = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge ref_clk);
        if (comp_pulse) begin hi++; run++; end else begin lo++; run = 0; end
        if (run > 1) check(1'b0, "R5 pulse width", run, 1);
      end
      check(hi == 30 && lo == 30, "R5 duty at ratio 2", hi, 30);
    end

    sync_set(4'b1000, 1'b1, 1'b1, 0);
    @(negedge ref_clk); @(negedge ref_clk);
    check(code_err == 1'b1, "R3 err raised", code_err, 1);
    begin
      int n = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge ref_clk);
        if (comp_pulse) n++;
      end
      check(n == 0, "R3 no pulses", n, 0);
    end
    #1 cfg_wr = 1'b1; code_in = 4'd2;
    @(posedge ref_clk); #1 cfg_wr = 1'b0;
    @(negedge ref_clk); @(negedge ref_clk);
    check(code_err == 1'b0, "R3 err cleared", code_err, 0);
    cur = 4'd2;
    sync_set(4'd2, 1'b1, 1'b1, 2);

    sync_set(4'd2, 1'b1, 1'b0, 1);
    for (int i = 0; i < 6; i++) begin
      @(posedge ref_clk); #2;
      check(ref_comp_out == 1'b1, "R6 ref high phase", ref_comp_out, 1);
      @(negedge ref_clk); #2;
      check(ref_comp_out == 1'b0, "R6 ref low phase", ref_comp_out, 0);
    end

    sync_set(4'd2, 1'b0, 1'b1, 1);
    for (int i = 0; i < 20; i++) begin
      @(posedge ref_clk); #2;
      check(ref_comp_out == 1'b1, "R8 held high", ref_comp_out, 1);
      @(negedge ref_clk); #2;
      check(ref_comp_out == 1'b1, "R8 held high", ref_comp_out, 1);
    end

    sync_set(4'd2, 1'b1, 1'b1, 1);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge ref_clk);
        if (comp_pulse) seen++;
        check(ref_comp_out == comp_pulse, "R7 comp on output", ref_comp_out, comp_pulse);
      end
      check(seen == 5, "R7 pulses observed", seen, 5);
    end

    pe = 1'b1;
    @(posedge rf_clk); #1;
    begin
      logic prev;
      prev = rf_out;
      for (int i = 0; i < 20; i++) begin
        @(posedge rf_clk); #1;
        check(rf_out != prev, "R10 prescaler toggles", rf_out, !prev);
        prev = rf_out;
      end
    end
    pe = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge rf_clk); #1;
      check(rf_out == 1'b1, "R10 bypass high", rf_out, 1);
      @(negedge rf_clk); #1;
      check(rf_out == 1'b0, "R10 bypass low", rf_out, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule